// File: doc/BRIEF.md
# UART Modem Control and Diagnostic Loopback

This block holds the modem control register of a UART and steers the serial and modem-handshake pins around it. Software writes a byte to set the two active-low handshake outputs (terminal-ready and request-to-send) and to turn on a diagnostic loopback. The block also keeps a modem status byte. It reports the current true-sense level of the four handshake inputs and a change flag for each. Any pending change flag raises an interrupt request when the enable input allows it.

In normal operation the transmitter's serial bit goes to the output pin and the input pin goes to the receiver. The handshake inputs pass through a two-flop synchronizer before their changes are detected. In loopback, the transmitted bit is fed straight back into the receiver and the output pin idles at mark. The handshake outputs are parked high. The status inputs are then taken from the control register bits, so a register write can raise a modem interrupt without any pin moving.

The serial connections are single-wire bit levels that are sampled by the shift registers. They carry no valid/ready handshake and have no back-pressure. The register port is a plain write strobe plus combinational read data, with a read strobe on the status byte.

Top module: `uart_modem_ctl`

## Requirements
- R1: Control bit 0 sets the terminal-ready pin low when 1 and high when 0, starting from the clock edge that takes the write, while loopback (bit 4) is 0.
- R2: Control bit 1 drives the request-to-send pin with the same inverted sense as R1.
- R3: Control readback returns written bits 0, 1 and 4. Bits 2, 3, 5, 6 and 7 always read 0 (read mask 0x13).
- R4: With bit 4 set, the serial output pin is 1, the receiver input equals the transmitter bit, and the serial input pin has no effect.
- R5: With bit 4 set, both handshake output pins are high whatever bits 0 and 1 hold.
- R6: With bit 4 set, the status inputs ignore the pins. Clear-to-send follows bit 1, data-set-ready follows bit 0, and ring and carrier read 0. Status and deltas update on the edge after the register changes.
- R7: Out of loopback, a pin change shows in the status byte only after the third rising edge (two synchronizer flops plus the status register). Status bits 4, 5, 6 and 7 hold the true (inverted-pin) sense of clear-to-send, data-set-ready, ring and carrier.
- R8: Delta bit 0, bit 1 and bit 3 set on any change of clear-to-send, data-set-ready and carrier. Bit 2 sets only when ring goes from active to inactive.
- R9: A read strobe on the status byte clears all delta bits. A change detected in the same cycle still sets its bit. Without a read, set deltas stay set.
- R10: The interrupt request is high exactly when the enable input is 1 and a delta bit is set. In loopback a control write that changes bit 0 or 1 raises it.
- R11: Reset clears the control register, the status byte and the interrupt. The handshake outputs are high and loopback is off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr_en | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control write data |
| ctl_rdata | output | 8 | Control readback |
| msr_rd_en | input | 1 | Status read strobe, clears deltas |
| msr_rdata | output | 8 | Status byte: [7:4] levels, [3:0] deltas |
| msi_en_i | input | 1 | Modem status interrupt enable |
| msi_irq_o | output | 1 | Modem status interrupt request |
| dtr_n_o | output | 1 | Terminal-ready pin, active low |
| rts_n_o | output | 1 | Request-to-send pin, active low |
| cts_n_i | input | 1 | Clear-to-send pin, active low |
| dsr_n_i | input | 1 | Data-set-ready pin, active low |
| dcd_n_i | input | 1 | Carrier pin, active low |
| ri_n_i | input | 1 | Ring pin, active low |
| sin_i | input | 1 | Serial input pin |
| sout_o | output | 1 | Serial output pin |
| tx_shift_i | input | 1 | Bit from the transmitter shift register |
| rx_shift_o | output | 1 | Bit to the receiver shift register |

## Verification
The hardest case is a status read that lands in the same cycle as a new change being detected, where the new delta must survive the clear. The pins cannot line this up easily because of the synchronizer delay. The stimulus uses loopback instead, where a control write changes the status inputs with a known one-edge latency. The read strobe is placed exactly on the following edge. The ring trailing-edge rule is checked by driving ring active and inactive in turn, and confirming that only the release sets its delta.

// File: rtl/uart_mc_pkg.sv
package uart_mc_pkg;
  localparam int CTL_W      = 8;
  localparam int BIT_DTR    = 0;
  localparam int BIT_RTS    = 1;
  localparam int BIT_LOOP   = 4;
  localparam logic [CTL_W-1:0] CTL_RD_MASK = 8'h13;
  localparam int N_MODEM    = 4;

  // true-sense modem inputs, order matches status bits 7..4
  typedef struct packed {
    logic dcd;
    logic ri;
    logic dsr;
    logic cts;
  } modem_t;
endpackage

// File: rtl/mc_sync.sv
module mc_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  localparam int LAST = STAGES - 1;
  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg <= '1;
    end else begin
      stg[0] <= din;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign dout = stg[LAST];

  // R7: first stage captures the pin on every edge out of reset
  p_stage0_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> stg[0] == $past(din));
endmodule

// File: rtl/mc_ctl_reg.sv
module mc_ctl_reg
  import uart_mc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CTL_W-1:0] wdata,
  output logic [CTL_W-1:0] rdata,
  output logic             dtr_bit,
  output logic             rts_bit,
  output logic             loop_bit
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dtr_bit  <= 1'b0;
      rts_bit  <= 1'b0;
      loop_bit <= 1'b0;
    end else if (wr_en) begin
      dtr_bit  <= wdata[BIT_DTR];
      rts_bit  <= wdata[BIT_RTS];
      loop_bit <= wdata[BIT_LOOP];
    end
  end

  always_comb begin
    rdata           = '0;
    rdata[BIT_DTR]  = dtr_bit;
    rdata[BIT_RTS]  = rts_bit;
    rdata[BIT_LOOP] = loop_bit;
  end

  // R3: readback after a write equals the written byte under the mask
  p_rdback_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> rdata == ($past(wdata) & CTL_RD_MASK));
endmodule

// File: rtl/mc_status.sv
module mc_status
  import uart_mc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  modem_t     cur,
  input  logic       rd_en,
  input  logic       msi_en,
  output logic [7:0] rdata,
  output logic       irq
);
  modem_t     now_q;
  logic [3:0] delta_q;
  logic [3:0] delta_set;

  // bit0 cts change, bit1 dsr change, bit2 ring release, bit3 carrier change
  assign delta_set = {cur.dcd ^ now_q.dcd,
                      now_q.ri & ~cur.ri,
                      cur.dsr ^ now_q.dsr,
                      cur.cts ^ now_q.cts};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      now_q   <= '0;
      delta_q <= '0;
    end else begin
      now_q   <= cur;
      delta_q <= (rd_en ? 4'b0 : delta_q) | delta_set;
    end
  end

  assign rdata = {now_q, delta_q};
  assign irq   = msi_en & (|delta_q);

  // R9: deltas persist until read
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> (delta_q & $past(delta_q)) == $past(delta_q));
  // R9: a read with no new change leaves no delta
  p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && (cur == now_q) |=> delta_q == 4'b0);
  // R8: ring becoming active never sets its delta
  p_ri_lead_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && cur.ri && !now_q.ri |=> !delta_q[2]);
endmodule

// File: rtl/uart_modem_ctl.sv
module uart_modem_ctl
  import uart_mc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctl_wr_en,
  input  logic [7:0] ctl_wdata,
  output logic [7:0] ctl_rdata,
  input  logic       msr_rd_en,
  output logic [7:0] msr_rdata,
  input  logic       msi_en_i,
  output logic       msi_irq_o,
  output logic       dtr_n_o,
  output logic       rts_n_o,
  input  logic       cts_n_i,
  input  logic       dsr_n_i,
  input  logic       dcd_n_i,
  input  logic       ri_n_i,
  input  logic       sin_i,
  output logic       sout_o,
  input  logic       tx_shift_i,
  output logic       rx_shift_o
);
  logic               dtr_bit, rts_bit, loop_bit;
  logic [N_MODEM-1:0] pins_sync_n;
  modem_t             pin_sense, loop_sense, cur_sense;

  mc_ctl_reg u_ctl (
    .clk(clk), .rst_n(rst_n), .wr_en(ctl_wr_en), .wdata(ctl_wdata),
    .rdata(ctl_rdata), .dtr_bit(dtr_bit), .rts_bit(rts_bit), .loop_bit(loop_bit)
  );

  mc_sync #(.W(N_MODEM), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .din({dcd_n_i, ri_n_i, dsr_n_i, cts_n_i}),
    .dout(pins_sync_n)
  );

  always_comb begin
    pin_sense      = modem_t'(~pins_sync_n);
    // internal cross-wiring; bits 2 and 3 are not stored, so ring and carrier stay 0
    loop_sense.cts = rts_bit;
    loop_sense.dsr = dtr_bit;
    loop_sense.ri  = 1'b0;
    loop_sense.dcd = 1'b0;
    cur_sense      = loop_bit ? loop_sense : pin_sense;
  end

  mc_status u_stat (
    .clk(clk), .rst_n(rst_n), .cur(cur_sense), .rd_en(msr_rd_en),
    .msi_en(msi_en_i), .rdata(msr_rdata), .irq(msi_irq_o)
  );

  assign dtr_n_o    = loop_bit | ~dtr_bit;
  assign rts_n_o    = loop_bit | ~rts_bit;
  assign sout_o     = loop_bit | tx_shift_i;
  assign rx_shift_o = loop_bit ? tx_shift_i : sin_i;

  // R1 / R2: inverted drive of the handshake pins after a normal-mode write
  p_drive_pol_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr_en && !ctl_wdata[BIT_LOOP] |=>
      (dtr_n_o == !$past(ctl_wdata[BIT_DTR])) && (rts_n_o == !$past(ctl_wdata[BIT_RTS])));
  // R5 / R4: loopback parks handshake pins and serial output
  p_lb_park_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr_en && ctl_wdata[BIT_LOOP] |=> dtr_n_o && rts_n_o && sout_o);
  // R6: in loopback, clear-to-send status tracks the written request bit
  p_lb_cts_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_rdata[BIT_LOOP] && ctl_wr_en && ctl_wdata[BIT_LOOP] |=> ##1
      msr_rdata[4] == $past(ctl_wdata[BIT_RTS], 2));
  // R10: a loopback write that flips the request bit raises the interrupt
  p_lb_irq_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_rdata[BIT_LOOP] && ctl_wr_en && ctl_wdata[BIT_LOOP] &&
    (ctl_wdata[BIT_RTS] != ctl_rdata[BIT_RTS]) |=> ##1 (msi_irq_o || !msi_en_i));
endmodule

// File: tb/test_uart_modem_ctl.sv
module test_uart_modem_ctl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ctl_wr_en = 1'b0, msr_rd_en = 1'b0, msi_en_i = 1'b0;
  logic [7:0] ctl_wdata = '0;
  logic [7:0] ctl_rdata, msr_rdata;
  logic msi_irq_o, dtr_n_o, rts_n_o, sout_o, rx_shift_o;
  logic cts_n_i = 1'b1, dsr_n_i = 1'b1, dcd_n_i = 1'b1, ri_n_i = 1'b1;
  logic sin_i = 1'b0, tx_shift_i = 1'b0;
  int checks = 0, failures = 0;

  always #5 clk = ~clk;

  uart_modem_ctl i_uart_modem_ctl (
    .clk(clk), .rst_n(rst_n), .ctl_wr_en(ctl_wr_en), .ctl_wdata(ctl_wdata),
    .ctl_rdata(ctl_rdata), .msr_rd_en(msr_rd_en), .msr_rdata(msr_rdata),
    .msi_en_i(msi_en_i), .msi_irq_o(msi_irq_o), .dtr_n_o(dtr_n_o), .rts_n_o(rts_n_o),
    .cts_n_i(cts_n_i), .dsr_n_i(dsr_n_i), .dcd_n_i(dcd_n_i), .ri_n_i(ri_n_i),
    .sin_i(sin_i), .sout_o(sout_o), .tx_shift_i(tx_shift_i), .rx_shift_o(rx_shift_o)
  );

  // {write byte, readback, dtr_n, rts_n, sout} with tx_shift_i held at 0
  localparam logic [18:0] VECS [9] = '{
    {8'h00, 8'h00, 3'b110}, {8'h01, 8'h01, 3'b010}, {8'h02, 8'h02, 3'b100},
    {8'h03, 8'h03, 3'b000}, {8'hFF, 8'h13, 3'b111}, {8'hEC, 8'h00, 3'b110},
    {8'h13, 8'h13, 3'b111}, {8'h10, 8'h10, 3'b111}, {8'h23, 8'h03, 3'b000}
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk); ctl_wr_en = 1'b1; ctl_wdata = d;
    @(negedge clk); ctl_wr_en = 1'b0;
  endtask

  task automatic rd_msr();
    @(negedge clk); msr_rd_en = 1'b1;
    @(negedge clk); msr_rd_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    idle(2);
    chk("R11 reset ctl", ctl_rdata, 8'h00);
    chk("R11 reset pins", {6'b0, dtr_n_o, rts_n_o}, 8'h03);
    chk("R11 reset msr", msr_rdata, 8'h00);
    chk("R11 reset irq", {7'b0, msi_irq_o}, 8'h00);
    rst_n = 1'b1;
    idle(1);

    for (int i = 0; i < 9; i++) begin
      wr(VECS[i][18:11]);
      chk($sformatf("R3 readback row %0d", i), ctl_rdata, VECS[i][10:3]);
      chk($sformatf("R1/R5 dtr row %0d", i), {7'b0, dtr_n_o}, {7'b0, VECS[i][2]});
      chk($sformatf("R2/R5 rts row %0d", i), {7'b0, rts_n_o}, {7'b0, VECS[i][1]});
      chk($sformatf("R4 sout row %0d", i), {7'b0, sout_o}, {7'b0, VECS[i][0]});
    end

    wr(8'h00); idle(3); rd_msr();
    chk("R9 cleared", msr_rdata, 8'h00);

    msi_en_i = 1'b1;
    @(negedge clk); cts_n_i = 1'b0;
    idle(2);
    chk("R7 not yet at edge 2", msr_rdata, 8'h00);
    chk("R10 no irq yet", {7'b0, msi_irq_o}, 8'h00);
    idle(1);
    chk("R7 cts after edge 3", msr_rdata, 8'h11);
    chk("R10 irq raised", {7'b0, msi_irq_o}, 8'h01);
    rd_msr();
    chk("R9 read clears", msr_rdata, 8'h10);
    chk("R10 irq dropped", {7'b0, msi_irq_o}, 8'h00);

    @(negedge clk); ri_n_i = 1'b0; idle(4);
    chk("R8 ring lead no delta", msr_rdata, 8'h50);
    ri_n_i = 1'b1; idle(4);
    chk("R8 ring trail delta", msr_rdata, 8'h14);
    rd_msr();

    dsr_n_i = 1'b0; dcd_n_i = 1'b0; idle(4);
    chk("R8 dsr dcd deltas", msr_rdata, 8'hBA);
    rd_msr();
    chk("R9 clear keeps levels", msr_rdata, 8'hB0);

    wr(8'h10);
    tx_shift_i = 1'b1; sin_i = 1'b0; #1;
    chk("R4 loop rx follows tx 1", {6'b0, rx_shift_o, sout_o}, 8'h03);
    tx_shift_i = 1'b0; sin_i = 1'b1; #1;
    chk("R4 loop rx follows tx 0", {6'b0, rx_shift_o, sout_o}, 8'h01);
    idle(2); rd_msr();
    chk("R6 pins ignored in loop", msr_rdata, 8'h00);

    wr(8'h12); idle(1);
    chk("R6 cts from rts bit", msr_rdata, 8'h11);
    chk("R10 irq from write", {7'b0, msi_irq_o}, 8'h01);
    cts_n_i = 1'b1; idle(4);
    chk("R6 cts pin ignored", msr_rdata, 8'h11);
    rd_msr();
    wr(8'h13); idle(1);
    chk("R6 dsr from dtr bit", msr_rdata, 8'h32);
    chk("R5 pins parked", {6'b0, dtr_n_o, rts_n_o}, 8'h03);
    rd_msr();

    @(negedge clk); ctl_wr_en = 1'b1; ctl_wdata = 8'h11;
    @(negedge clk); ctl_wr_en = 1'b0; msr_rd_en = 1'b1;
    @(negedge clk); msr_rd_en = 1'b0;
    chk("R9 set beats clear", msr_rdata, 8'h21);

    msi_en_i = 1'b0; #1;
    chk("R10 gated off", {7'b0, msi_irq_o}, 8'h00);
    msi_en_i = 1'b1; #1;
    chk("R10 gated on", {7'b0, msi_irq_o}, 8'h01);

    @(negedge clk); rst_n = 1'b0; #1;
    chk("R11 mid reset ctl", ctl_rdata, 8'h00);
    chk("R11 mid reset pins", {5'b0, dtr_n_o, rts_n_o, msi_irq_o}, 8'h06);
    chk("R11 mid reset msr", msr_rdata, 8'h00);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule